// File: doc/BRIEF.md
# Synchronous SRAM with Selectable Output Stage

This block is a small on-chip synchronous SRAM. Its word is split into four byte lanes. Chip enable, address, write data and the write controls are sampled on the rising clock edge. One cycle can be a read, a write or a deselect. A write either updates the byte lanes named by a per-lane select vector or, through the global-write input, updates every lane. The address comes from an external burst counter that sits outside this block.

A static mode input chooses how read data reaches the output:

- **Flow-through:** data comes straight from the storage array and appears one cycle sooner.
- **Pipelined:** data passes through a rising-edge output register.

The output-valid indication travels down the same pipeline as the read data, so a deselect takes effect with the same latency as a read. In pipelined mode the output therefore stays on for one full cycle after a deselect and turns off only after the second edge.

Output enable acts combinationally on the output. The sleep input blocks every new operation and leaves the stored contents intact.

Top module: `sram_sync_top`

## Requirements
- R1: After a synchronous reset with `oe` high, `rvalid` is 0 and `rdata` is 0 until a read is accepted.
- R2: With `mode_pipe` = 0, a read sampled at clock edge k shows the addressed word on `rdata` with `rvalid` = 1 in the interval from edge k to edge k+1.
- R3: With `mode_pipe` = 1, a read sampled at edge k shows the addressed word with `rvalid` = 1 in the interval from edge k+1 to edge k+2.
- R4: A cycle that is not a read turns the output off after the same number of edges as a read turns it on: after edge k in flow-through mode, after edge k+1 in pipelined mode. When no read is due, `rvalid` is 0 and `rdata` is 0.
- R5: When `bwe` is 1 and `bsel` is non-zero (with `gwr` = 0), the cycle is a write. Only lane i, meaning bits [8i+7:8i], is updated for each `bsel[i]` = 1.
- R6: When `bwe` is 1 with `bsel` = 0, or when `bsel` is non-zero with `bwe` = 0, and `gwr` is 0, the cycle is a read and memory is left unchanged.
- R7: When `gwr` is 1, all four lanes are written, whatever the values of `bwe` and `bsel`.
- R8: While `sleep` is 1, no read or write is accepted, the output turns off as for a deselect, and the stored contents are retained.
- R9: When `oe` is 0, `rvalid` and `rdata` are 0 at once, without waiting for a clock edge. Raising `oe` restores the pending read data within the same cycle.
- R10: In pipelined mode, a write sampled at the edge that loads a read's data into the output register does not alter the data presented, even when the write targets the same address.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Synchronous active-low reset of the read pipeline |
| mode_pipe | input | 1 | Static output-stage select: 1 = pipelined, 0 = flow-through |
| sleep | input | 1 | Asynchronous sleep; blocks all operations |
| ce | input | 1 | Chip enable; 0 = deselect cycle |
| gwr | input | 1 | Global write of all lanes |
| bwe | input | 1 | Byte-write enable |
| bsel | input | 4 | Per-lane write select, bit i = lane i |
| addr | input | 6 | Word address from the external burst counter |
| wdata | input | 32 | Write data |
| oe | input | 1 | Asynchronous output enable |
| rdata | output | 32 | Read data, 0 when not valid |
| rvalid | output | 1 | Read data valid / output driven |

## Verification
The case of interest is a pipelined read followed at the very next edge by a write to the same address. That edge both loads the output register from the array and updates the array. The bench issues a read and then a global write of new data to the same word on back-to-back cycles. The scoreboard expects the old value in the cycle after the write edge and the new value on a later read. The bench also mixes reads with deselect and sleep cycles in both output modes, and checks every cycle where the output must be off.

// File: rtl/sram_sync_pkg.sv
// Package: shared types for the synchronous SRAM.
// Assumes: one operation per clock cycle, decoded from the sampled controls.
package sram_sync_pkg;
    typedef enum logic [1:0] {
        OP_IDLE  = 2'd0,
        OP_READ  = 2'd1,
        OP_WRITE = 2'd2
    } sram_op_e;
endpackage

// File: rtl/sram_op_decode.sv
// Module: sram_op_decode
// Turns the sampled controls into one operation and a per-lane write mask.
// Assumes: inputs are stable around the rising edge, except sleep, which
// acts combinationally and masks everything.
module sram_op_decode
    import sram_sync_pkg::*;
#(
    parameter int LANES = 4
) (
    input  logic             ce,
    input  logic             sleep,
    input  logic             gwr,
    input  logic             bwe,
    input  logic [LANES-1:0] bsel,
    output sram_op_e         op,
    output logic [LANES-1:0] lane_we
);
    logic wr_hit;

    // Pick the cycle type: sleep or deselect first, then write, else read.
    always_comb begin
        wr_hit = gwr | (bwe & (|bsel));
        if (sleep || !ce) begin
            op = OP_IDLE;
        end else if (wr_hit) begin
            op = OP_WRITE;
        end else begin
            op = OP_READ;
        end
    end

    // Lane mask: global write covers all lanes, byte write only the selected ones.
    always_comb begin
        if (op != OP_WRITE) begin
            lane_we = '0;
        end else if (gwr) begin
            lane_we = '1;
        end else begin
            lane_we = bsel;
        end
    end
endmodule

// File: rtl/sram_store.sv
// Module: sram_store
// Storage array with one lane-masked write port and one asynchronous read port.
// Assumes: contents are not reset; the array keeps its data across reset and sleep.
module sram_store #(
    parameter int ADDR_W = 6,
    parameter int LANES  = 4,
    parameter int LANE_W = 8
) (
    input  logic                      clk,
    input  logic [ADDR_W-1:0]         wr_addr,
    input  logic [LANES*LANE_W-1:0]   wdata,
    input  logic [LANES-1:0]          lane_we,
    input  logic [ADDR_W-1:0]         rd_addr,
    output logic [LANES*LANE_W-1:0]   rd_word
);
    localparam int DEPTH = 1 << ADDR_W;

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        logic [LANE_W-1:0] mem [DEPTH];

        // Update this lane when its write enable is set.
        always_ff @(posedge clk) begin
            if (lane_we[g]) begin
                mem[wr_addr] <= wdata[g*LANE_W +: LANE_W];
            end
        end

        assign rd_word[g*LANE_W +: LANE_W] = mem[rd_addr];
    end
endmodule

// File: rtl/sram_read_pipe.sv
// Module: sram_read_pipe
// Read data path: address stage, optional output register, valid pipeline
// (deselects travel at read depth) and output-enable gating.
// Assumes: mode_pipe is static while reads are in flight.
module sram_read_pipe #(
    parameter int ADDR_W = 6,
    parameter int WORD_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              mode_pipe,
    input  logic              oe,
    input  logic              rd_req,
    input  logic [ADDR_W-1:0] rd_addr_in,
    input  logic [WORD_W-1:0] rd_word,
    output logic [ADDR_W-1:0] rd_addr_q,
    output logic [WORD_W-1:0] rdata,
    output logic              rvalid
);
    logic              s1_act;
    logic              s2_act;
    logic [WORD_W-1:0] out_q;
    logic              act_sel;
    logic [WORD_W-1:0] data_sel;

    // First stage: remember that a read was accepted, and its address.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s1_act    <= 1'b0;
            rd_addr_q <= '0;
        end else begin
            s1_act <= rd_req;
            if (rd_req) begin
                rd_addr_q <= rd_addr_in;
            end
        end
    end

    // Second stage: output register and delayed valid for pipelined mode.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s2_act <= 1'b0;
            out_q  <= '0;
        end else begin
            s2_act <= s1_act;
            if (s1_act) begin
                out_q <= rd_word;
            end
        end
    end

    // Output stage: pick the source by mode, then gate by output enable.
    always_comb begin
        act_sel  = mode_pipe ? s2_act : s1_act;
        data_sel = mode_pipe ? out_q : rd_word;
        rvalid   = oe & act_sel;
        rdata    = rvalid ? data_sel : '0;
    end

    p_flow_latency_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (!mode_pipe && rd_req) |=> act_sel);

    p_pipe_latency_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_pipe && s1_act) |=> act_sel);

    p_pipe_deselect_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_pipe && !s1_act) |=> !act_sel);

    p_flow_deselect_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (!mode_pipe && !rd_req) |=> !act_sel);

    p_out_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !s1_act |=> $stable(out_q));

    // Output enable low forces the outputs off at once.
    always_comb begin
        if (!oe) begin
            p_oe_gate_r9: assert (rvalid == 1'b0 && rdata == '0);
        end
    end
endmodule

// File: rtl/sram_sync_top.sv
// Module: sram_sync_top
// Synchronous SRAM: decode, lane-masked storage and a read path that is
// either flow-through or pipelined.
// Assumes: addr comes from an external burst counter; mode_pipe is static.
module sram_sync_top
    import sram_sync_pkg::*;
#(
    parameter int ADDR_W = 6,
    parameter int LANES  = 4,
    parameter int LANE_W = 8
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    mode_pipe,
    input  logic                    sleep,
    input  logic                    ce,
    input  logic                    gwr,
    input  logic                    bwe,
    input  logic [LANES-1:0]        bsel,
    input  logic [ADDR_W-1:0]       addr,
    input  logic [LANES*LANE_W-1:0] wdata,
    input  logic                    oe,
    output logic [LANES*LANE_W-1:0] rdata,
    output logic                    rvalid
);
    localparam int WORD_W = LANES * LANE_W;

    sram_op_e          op;
    logic [LANES-1:0]  lane_we;
    logic              rd_req;
    logic [ADDR_W-1:0] rd_addr_q;
    logic [WORD_W-1:0] rd_word;

    sram_op_decode #(.LANES(LANES)) u_decode (
        .ce      (ce),
        .sleep   (sleep),
        .gwr     (gwr),
        .bwe     (bwe),
        .bsel    (bsel),
        .op      (op),
        .lane_we (lane_we)
    );

    assign rd_req = (op == OP_READ);

    sram_store #(.ADDR_W(ADDR_W), .LANES(LANES), .LANE_W(LANE_W)) u_store (
        .clk     (clk),
        .wr_addr (addr),
        .wdata   (wdata),
        .lane_we (lane_we),
        .rd_addr (rd_addr_q),
        .rd_word (rd_word)
    );

    sram_read_pipe #(.ADDR_W(ADDR_W), .WORD_W(WORD_W)) u_read (
        .clk        (clk),
        .rst_n      (rst_n),
        .mode_pipe  (mode_pipe),
        .oe         (oe),
        .rd_req     (rd_req),
        .rd_addr_in (addr),
        .rd_word    (rd_word),
        .rd_addr_q  (rd_addr_q),
        .rdata      (rdata),
        .rvalid     (rvalid)
    );

    p_sleep_blocks_r8: assert property (@(posedge clk) disable iff (!rst_n)
        sleep |-> (lane_we == '0 && !rd_req));

    p_no_lane_no_write_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (!gwr && (!bwe || bsel == '0)) |-> lane_we == '0);
endmodule

// File: tb/sram_sync_top_bench.sv
`timescale 1ns/1ps
module sram_sync_top_bench;
    localparam int AW = 6;
    localparam int DEPTH = 1 << AW;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        mode_pipe = 1'b0;
    logic        sleep = 1'b0;
    logic        ce = 1'b0;
    logic        gwr = 1'b0;
    logic        bwe = 1'b0;
    logic [3:0]  bsel = '0;
    logic [AW-1:0] addr = '0;
    logic [31:0] wdata = '0;
    logic        oe = 1'b1;
    logic [31:0] rdata;
    logic        rvalid;

    sram_sync_top #(.ADDR_W(AW), .LANES(4), .LANE_W(8)) u_sram_sync_top (
        .clk(clk), .rst_n(rst_n), .mode_pipe(mode_pipe), .sleep(sleep),
        .ce(ce), .gwr(gwr), .bwe(bwe), .bsel(bsel), .addr(addr),
        .wdata(wdata), .oe(oe), .rdata(rdata), .rvalid(rvalid)
    );

    always #2.5 clk = ~clk;

    typedef struct {
        int          due;
        logic [31:0] data;
        string       tag;
    } item_t;

    item_t       q[$];
    logic [31:0] ref_mem [DEPTH];
    int          cyc = 0;
    int          vectors = 0;
    int          fails = 0;
    bit          mon_on = 1'b0;

    always @(posedge clk) cyc <= cyc + 1;

    task automatic chk(input bit ok, input string tag,
                       input logic [32:0] act, input logic [32:0] exp);
        vectors++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual={v,d}=%h expected=%h at cycle %0d", tag, act, exp, cyc);
        end
    endtask

    task automatic summary();
        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    endtask

    // Driver: one operation per cycle, reference model updated, reads queued.
    task automatic drive(input bit c, input bit s, input bit g, input bit b,
                         input logic [3:0] bs, input logic [AW-1:0] a,
                         input logic [31:0] d, input string tag);
        item_t it;
        @(negedge clk);
        ce = c; sleep = s; gwr = g; bwe = b; bsel = bs; addr = a; wdata = d;
        if (!s && c) begin
            if (g || (b && bs != 4'd0)) begin
                for (int i = 0; i < 4; i++) begin
                    if (g || bs[i]) ref_mem[a][i*8 +: 8] = d[i*8 +: 8];
                end
            end else begin
                it.due  = cyc + 1 + (mode_pipe ? 1 : 0);
                it.data = ref_mem[a];
                it.tag  = tag;
                q.push_back(it);
            end
        end
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) drive(1'b0, 1'b0, 1'b0, 1'b0, 4'd0, '0, '0, "R4");
    endtask

    task automatic rd(input logic [AW-1:0] a, input string tag);
        drive(1'b1, 1'b0, 1'b0, 1'b0, 4'd0, a, '0, tag);
    endtask

    task automatic gw(input logic [AW-1:0] a, input logic [31:0] d);
        drive(1'b1, 1'b0, 1'b1, 1'b0, 4'd0, a, d, "R7");
    endtask

    // Monitor: compares every cycle, expecting silence when no read is due.
    always @(posedge clk) begin
        #1;
        if (mon_on) begin
            if (q.size() > 0 && q[0].due < cyc) begin
                chk(1'b0, {q[0].tag, " missed"}, {rvalid, rdata}, {1'b1, q[0].data});
                void'(q.pop_front());
            end
            if (q.size() > 0 && q[0].due == cyc) begin
                chk(rvalid === 1'b1 && rdata === q[0].data, q[0].tag,
                    {rvalid, rdata}, {1'b1, q[0].data});
                void'(q.pop_front());
            end else begin
                chk(rvalid === 1'b0 && rdata === 32'd0, "R4 idle",
                    {rvalid, rdata}, 33'd0);
            end
        end
    end

    initial begin
        #1_000_000;
        fails++;
        $display("FAIL watchdog expired at cycle %0d", cyc);
        summary();
        $finish;
    end

    initial begin
        for (int i = 0; i < DEPTH; i++) ref_mem[i] = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(posedge clk); #1;
        // R1: reset state with oe high
        chk(rvalid === 1'b0 && rdata === 32'd0, "R1", {rvalid, rdata}, 33'd0);

        // Flow-through mode: fill, then read back
        mode_pipe = 1'b0;
        mon_on = 1'b1;
        for (int i = 0; i < 16; i++) gw(AW'(i), 32'h1000_0000 + i * 32'h0103_0507);
        for (int i = 0; i < 16; i++) rd(AW'(i), "R2");
        idle(1);
        rd(AW'(3), "R2");
        idle(2);

        // R5: byte write of lanes 0 and 2
        drive(1'b1, 1'b0, 1'b0, 1'b1, 4'b0101, AW'(3), 32'hAABB_CCDD, "R5");
        rd(AW'(3), "R5");
        // R6: bwe without lanes, and lanes without bwe, are reads
        drive(1'b1, 1'b0, 1'b0, 1'b1, 4'b0000, AW'(4), 32'hDEAD_BEEF, "R6");
        drive(1'b1, 1'b0, 1'b0, 1'b0, 4'b1111, AW'(4), 32'hDEAD_BEEF, "R6");
        rd(AW'(4), "R6");
        // R7: global write overrides the lane selects
        drive(1'b1, 1'b0, 1'b1, 1'b1, 4'b0001, AW'(6), 32'h1234_5678, "R7");
        rd(AW'(6), "R7");
        // R8: sleep blocks a write and a read
        drive(1'b1, 1'b1, 1'b1, 1'b0, 4'd0, AW'(5), 32'h5555_AAAA, "R8");
        drive(1'b1, 1'b1, 1'b0, 1'b0, 4'd0, AW'(6), '0, "R8");
        rd(AW'(5), "R8");
        idle(3);

        // R9: asynchronous output enable, flow-through read of address 2
        mon_on = 1'b0;
        rd(AW'(2), "R9");
        @(posedge clk); #1;
        oe = 1'b0; #1;
        chk(rvalid === 1'b0 && rdata === 32'd0, "R9 off", {rvalid, rdata}, 33'd0);
        oe = 1'b1; #1;
        chk(rvalid === 1'b1 && rdata === ref_mem[2], "R9 on", {rvalid, rdata}, {1'b1, ref_mem[2]});
        idle(3);
        q.delete();

        // Pipelined mode
        mode_pipe = 1'b1;
        idle(1);
        mon_on = 1'b1;
        for (int i = 0; i < 8; i++) rd(AW'(i), "R3");
        idle(1);
        rd(AW'(9), "R3");
        idle(1);
        rd(AW'(10), "R3");
        rd(AW'(11), "R3");
        idle(2);
        // R10: read then write same address on the next edge
        rd(AW'(7), "R10");
        gw(AW'(7), 32'hCAFE_F00D);
        rd(AW'(7), "R10");
        // R5 and R8 in pipelined mode
        drive(1'b1, 1'b0, 1'b0, 1'b1, 4'b1000, AW'(8), 32'h77FF_FFFF, "R5");
        rd(AW'(8), "R5");
        drive(1'b1, 1'b1, 1'b0, 1'b0, 4'd0, AW'(8), '0, "R8");
        rd(AW'(8), "R8");
        idle(4);

        if (q.size() != 0) chk(1'b0, "R4 drain", 33'(q.size()), 33'd0);
        mon_on = 1'b0;
        summary();
        $finish;
    end
endmodule